// File: doc/BRIEF.md
# Hot-Plug Bus Connection Sequencer

This controller decides when the backplane half and the card half of a buffered two-wire serial bus (I2C/SMBus) may be joined. A card plugged into a live system must not join its lines to the backplane in the middle of a transfer. The controller therefore watches the backplane lines for the end of a transaction. That end is either a STOP condition or a quiet interval in which both lines stay high. Before it closes the link, it also checks that the card side is released.

The `link` output drives the pass devices that perform the wired-AND joining. `rdy` reports the link state to the rest of the system. A supply-good flag, an enable input and a stuck-bus fault flag from a recovery unit can each hold the link open. After a stuck-bus fault has been seen, a rising edge on enable closes the link at once and skips the usual checks. This lets a supervisor push a connection through a bus that is still busy.

All bus lines and the enable input pass through two-flop synchronizers. The supply-good and fault flags are taken as signals already in the clock domain.

Top module: `bus_join_seq`

## Requirements
- R1: While `pwr_ok` is low, `link` is low. Bus activity and quiet time seen while `pwr_ok` is low do not count toward a later connection.
- R2: With `en` high, `pwr_ok` high, `fault` low and both card lines high, a STOP on the backplane closes the link within 6 clock cycles. A STOP is a rise of `bp_sda` while `bp_scl` stays high, and no idle interval is needed for it.
- R3: If both backplane lines are high with no edge for `IDLE_CYCLES` cycles, the link closes within `IDLE_CYCLES`+6 cycles. It does not close earlier than `IDLE_CYCLES` cycles.
- R4: The link does not close while either card line is low. Once both card lines are high, it closes within 6 cycles.
- R5: `rdy` equals `link` in every cycle, and both are low after reset.
- R6: When `en` goes low, the link opens within 4 cycles. When `en` returns high, a fresh STOP or idle interval is needed before the link closes again.
- R7: When `fault` is high, the link opens within 1 cycle. After `fault` clears, reconnection needs a fresh STOP or idle interval and released card lines.
- R8: After a fault has been seen, a rising edge on `en` closes the link within 4 cycles even if the card lines are low and the backplane is busy. This happens only once per fault, so a later `en` edge with no new fault does not force the link.
- R9: Any edge on `bp_sda` or `bp_scl` restarts the idle interval. SCL toggling with SDA held low, at gaps shorter than `IDLE_CYCLES`, never closes the link.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Supply-good flag, high when the supply is valid |
| en | input | 1 | Connection enable (asynchronous) |
| fault | input | 1 | Stuck-bus fault from the recovery unit |
| bp_sda | input | 1 | Backplane data line level |
| bp_scl | input | 1 | Backplane clock line level |
| cd_sda | input | 1 | Card data line level |
| cd_scl | input | 1 | Card clock line level |
| link | output | 1 | High while the two sides are joined |
| rdy | output | 1 | Connection status flag |

## Verification
The case that is hardest to reach from the ports is the forced connection. It needs a fault to come and go, then `en` to fall and rise while the card is still stuck low and the backplane is busy. After that, a second `en` edge must not force the link again. The stimulus builds this sequence with directed steps. The backplane pattern that must never count as idle is made from random SCL toggle gaps, drawn from a fixed seed, with SDA held low so that no STOP can appear. Each gap is shorter than the idle interval.

// File: rtl/bus_join_seq.sv
module bus_join_seq #(
  parameter int IDLE_CYCLES = 9500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic en,
  input  logic fault,
  input  logic bp_sda,
  input  logic bp_scl,
  input  logic cd_sda,
  input  logic cd_scl,
  output logic link,
  output logic rdy
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);

  typedef enum logic [1:0] {WAIT_END, ARMED, JOINED} st_t;

  logic [4:0] m1, m2;
  logic       p_sda, p_scl, p_en;
  logic [CW-1:0] idle_cnt;
  logic       fault_seen;
  st_t        st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 5'b0;
      m2 <= 5'b0;
      p_sda <= 1'b0;
      p_scl <= 1'b0;
      p_en  <= 1'b0;
    end else begin
      m1 <= {en, cd_scl, cd_sda, bp_scl, bp_sda};
      m2 <= m1;
      p_sda <= m2[0];
      p_scl <= m2[1];
      p_en  <= m2[4];
    end
  end

  wire s_sda  = m2[0];
  wire s_scl  = m2[1];
  wire cd_rel = m2[2] & m2[3];
  wire en_s   = m2[4];

  wire gate     = pwr_ok & en_s & ~fault;
  wire bp_edge  = (s_sda ^ p_sda) | (s_scl ^ p_scl);
  wire stop_det = ~p_sda & s_sda & p_scl & s_scl;
  wire idle_hit = (idle_cnt == CW'(IDLE_CYCLES));
  wire force_ev = en_s & ~p_en & fault_seen & pwr_ok & ~fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle_cnt <= '0;
    else if (!gate || bp_edge || !(s_sda & s_scl))
      idle_cnt <= '0;
    else if (!idle_hit)
      idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fault_seen <= 1'b0;
    else if (fault)
      fault_seen <= 1'b1;
    else if (force_ev)
      fault_seen <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st <= WAIT_END;
    else if (force_ev)
      st <= JOINED;
    else if (!gate)
      st <= WAIT_END;
    else begin
      case (st)
        WAIT_END: if (stop_det || idle_hit) st <= ARMED;
        ARMED:    if (cd_rel) st <= JOINED;
        default:  st <= JOINED;
      endcase
    end
  end

  assign link = (st == JOINED);
  assign rdy  = link;

  // R1
  pwr_off_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !link);

  // R4
  card_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link) |-> $past(cd_rel || force_ev));

  // R6
  en_low_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !link);

  // R7
  fault_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !link);

  // R8
  force_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_ev |=> link);

  // R5
  rdy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy == link);
endmodule

// File: tb/bus_join_seq_tb.sv
module bus_join_seq_tb;
  localparam int IDLE = 9500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0, en = 1'b0, fault = 1'b0;
  logic bp_sda = 1'b1, bp_scl = 1'b1, cd_sda = 1'b1, cd_scl = 1'b1;
  logic link, rdy;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_join_seq #(.IDLE_CYCLES(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .en(en), .fault(fault),
    .bp_sda(bp_sda), .bp_scl(bp_scl), .cd_sda(cd_sda), .cd_scl(cd_scl),
    .link(link), .rdy(rdy)
  );

  function automatic logic exp_link_after_cycles(int waited, int need);
    return waited >= need;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_stop();
    bp_scl = 1'b1;
    bp_sda = 1'b0;
    cyc(4);
    bp_sda = 1'b1;
  endtask

  task automatic reopen();
    en = 1'b0;
    cyc(6);
    en = 1'b1;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R5 reset state
    check("R5", link, 1'b0);
    check("R5", rdy, 1'b0);

    // R1: quiet bus while supply bad does not count
    en = 1'b1;
    cyc(IDLE + 50);
    check("R1", link, 1'b0);
    pwr_ok = 1'b1;
    cyc(20);
    check("R1", link, 1'b0);
    // R3: not early, then joins
    cyc(IDLE - 40);
    check("R3", link, exp_link_after_cycles(IDLE - 20, IDLE));
    cyc(30);
    check("R3", link, 1'b1);
    check("R5", rdy, link);

    // R6: enable low opens, enable high waits
    en = 1'b0;
    cyc(4);
    check("R6", link, 1'b0);
    check("R5", rdy, 1'b0);
    en = 1'b1;
    cyc(20);
    check("R6", link, 1'b0);
    // R2: stop joins quickly
    send_stop();
    cyc(6);
    check("R2", link, 1'b1);

    // R4: card low blocks
    reopen();
    cd_sda = 1'b0;
    send_stop();
    cyc(12);
    check("R4", link, 1'b0);
    cd_sda = 1'b1;
    cyc(6);
    check("R4", link, 1'b1);

    // R9: random SCL toggling with SDA low never looks idle
    reopen();
    bp_sda = 1'b0;
    bp_scl = 1'b0;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 24; i++) begin
      bp_scl = ~bp_scl;
      cyc(1 + ($urandom % (IDLE / 2)));
      check("R9", link, 1'b0);
    end
    bp_scl = 1'b1;
    cyc(3);
    bp_sda = 1'b1;
    cyc(6);
    check("R2", link, 1'b1);

    // R7: fault opens; reconnect needs normal conditions
    fault = 1'b1;
    cyc(1);
    check("R7", link, 1'b0);
    fault = 1'b0;
    cyc(20);
    check("R7", link, 1'b0);
    cyc(IDLE + 20);
    check("R7", link, 1'b1);

    // R8: forced join after fault with stuck card and busy bus
    cd_scl = 1'b0;
    bp_sda = 1'b0;
    fault = 1'b1;
    cyc(5);
    fault = 1'b0;
    en = 1'b0;
    cyc(6);
    check("R8", link, 1'b0);
    en = 1'b1;
    cyc(4);
    check("R8", link, 1'b1);
    check("R5", rdy, 1'b1);
    // R8: no second force without a new fault
    en = 1'b0;
    cyc(6);
    en = 1'b1;
    cyc(10);
    check("R8", link, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule